// File: doc/BRIEF.md
# Device Interrupt and Priority Mask Unit

This block keeps, for every device code on a small processor's I/O bus, a busy flag, a done flag and a disable flag. From these it decides when the CPU must take an interrupt. Devices raise and drop their flags with single-cycle strobes that carry a device code. The CPU drives the interrupt system with single-cycle commands: enable, disable, load a 16-bit priority mask, acknowledge, I/O reset and a flag skip test. It also sends a strobe on every instruction fetch.

A device requests service when its done flag is set and its disable flag is clear. The priority mask works on groups of devices. Each device belongs to one mask bit, and loading the mask disables every device whose group bit is set. After the enable command, one more instruction fetch must pass before an interrupt can be taken. When the block raises its take request, the CPU stores the PC at location 0 and jumps indirectly through the vector location the block reports. That location is 1 for device interrupts and 3 when a stack overflow is pending. The highest device code stands for the CPU itself. Skip tests on that code look at the interrupt enable and at the power-fail flag.

Top module: `dev_irq_ctrl`

## Requirements
- R1: After rst_n is released, all busy and done flags, interrupt enable, the fetch delay, the stack-overflow and power-fail flags and the mask are clear. irq_take is low.
- R2: A busy or done set strobe sets the flag of its code in the next cycle, and a clear strobe clears it. When a set and a clear of the same flag and code arrive in the same cycle, the clear wins.
- R3: cmd_mask_vld loads cmd_mask_data. Device d is disabled when the mask bit of its group is set. By default the group is (d / DEVS_PER_GRP) mod MASK_W, so devices 8 to 11 use bit 2 and device 30 uses bit 7. When GRP_FROM_ARRAY is set, the group comes from the DEV_GRP array instead. A disabled device neither raises an interrupt nor appears in an acknowledge.
- R4: The request set is the done flags AND NOT the disable flags. It follows every change of either at once.
- R5: cmd_ion sets the enable and a fetch delay. irq_take stays low until a later fetch strobe clears the delay. A fetch strobe in the same cycle as cmd_ion does not clear that delay.
- R6: irq_take is high exactly when the enable is set, no delay is pending, and a request or a stack overflow is active. The enable is clear in the cycle after irq_take.
- R7: irq_vec is 3 when a stack overflow is pending and 1 otherwise. Taking an interrupt with a stack overflow pending clears the stack-overflow flag. A device request that is still active stays pending.
- R8: cmd_iof clears the enable. When cmd_iof and cmd_ion arrive in the same cycle, cmd_iof wins.
- R9: In the cycle after cmd_ack, ack_vld is 1 and ack_code holds the lowest requesting device code, or 0 if no device is requesting.
- R10: In the cycle after skip_req, skip_vld is 1 and skip_hit gives the result of the test selected by skip_kind: 0 busy set, 1 busy clear, 2 done set, 3 done clear.
- R11: For the CPU code (all ones, 63 by default), the busy tests read the interrupt enable and the done tests read the power-fail flag. pwr_fail_set sets the power-fail flag.
- R12: cmd_iorst clears the enable, the delay, the stack-overflow flag, the power-fail flag, the mask and all disable flags. It leaves the busy and done flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_set_vld | input | 1 | Set a busy flag |
| busy_set_code | input | CODE_W | Device code for busy set |
| busy_clr_vld | input | 1 | Clear a busy flag |
| busy_clr_code | input | CODE_W | Device code for busy clear |
| done_set_vld | input | 1 | Set a done flag |
| done_set_code | input | CODE_W | Device code for done set |
| done_clr_vld | input | 1 | Clear a done flag |
| done_clr_code | input | CODE_W | Device code for done clear |
| pwr_fail_set | input | 1 | Raise the power-fail flag |
| stk_ovf_set | input | 1 | Raise the stack-overflow flag |
| fetch | input | 1 | Instruction fetch strobe |
| cmd_ion | input | 1 | Interrupt enable command |
| cmd_iof | input | 1 | Interrupt disable command |
| cmd_mask_vld | input | 1 | Load the priority mask |
| cmd_mask_data | input | MASK_W | New priority mask |
| cmd_ack | input | 1 | Interrupt acknowledge command |
| cmd_iorst | input | 1 | I/O reset command |
| skip_req | input | 1 | Skip test request |
| skip_kind | input | 2 | Skip test selector |
| skip_code | input | CODE_W | Device code under test |
| irq_take | output | 1 | CPU must take an interrupt now |
| irq_vec | output | 2 | Indirect vector location (1 or 3) |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_code | output | CODE_W | Lowest requesting device code |
| skip_vld | output | 1 | Skip result valid |
| skip_hit | output | 1 | Skip condition true |

## Verification
The assertions assume that the CPU issues no cmd_ion in the cycle when irq_take is high. In that cycle it is busy storing the PC and vectoring, not executing an instruction. They also assume that commands arrive as single-cycle pulses. The directed stimulus respects both assumptions. It issues each command on its own, waits one cycle after every strobe, and lets a take complete before it issues the next command. The only deliberate same-cycle collisions are the ones the requirements define: set against clear, enable against disable, and enable against fetch.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        SK_BUSY = 2'd0,
        SK_IDLE = 2'd1,
        SK_DONE = 2'd2,
        SK_PEND = 2'd3
    } skip_kind_e;

    localparam logic [1:0] VEC_DEV_LOC = 2'd1;
    localparam logic [1:0] VEC_STK_LOC = 2'd3;

endpackage

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
    parameter int NUM_DEV = 64,
    parameter int CODE_W  = $clog2(NUM_DEV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_vld,
    input  logic [CODE_W-1:0]  set_code,
    input  logic               clr_vld,
    input  logic [CODE_W-1:0]  clr_code,
    output logic [NUM_DEV-1:0] flags
);
    logic [NUM_DEV-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (set_vld && set_code == CODE_W'(i)) flags_d[i] = 1'b1;
            if (clr_vld && clr_code == CODE_W'(i)) flags_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    // R2: clear of a code always lands, even against a same-cycle set
    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vld |=> !flags_q[$past(clr_code)]);

    // R2: an uncontested set lands in the next cycle
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld && !(clr_vld && clr_code == set_code)) |=> flags_q[$past(set_code)]);

endmodule

// File: rtl/intc_mask_map.sv
module intc_mask_map #(
    parameter int NUM_DEV        = 64,
    parameter int MASK_W         = 16,
    parameter int GRP_W          = $clog2(MASK_W),
    parameter int DEVS_PER_GRP   = 4,
    parameter bit GRP_FROM_ARRAY = 1'b0,
    parameter logic [NUM_DEV*GRP_W-1:0] DEV_GRP = '0
) (
    input  logic [MASK_W-1:0]  mask,
    output logic [NUM_DEV-1:0] dis
);
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        localparam int GRP = GRP_FROM_ARRAY ? int'(DEV_GRP[d*GRP_W +: GRP_W])
                                            : (d / DEVS_PER_GRP) % MASK_W;
        assign dis[d] = mask[GRP];
    end
endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
    parameter int N = 64,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/dev_irq_ctrl.sv
module dev_irq_ctrl #(
    parameter int NUM_DEV        = 64,
    parameter int MASK_W         = 16,
    parameter int DEVS_PER_GRP   = 4,
    parameter bit GRP_FROM_ARRAY = 1'b0,
    parameter int GRP_W          = $clog2(MASK_W),
    parameter logic [NUM_DEV*GRP_W-1:0] DEV_GRP = '0,
    parameter int CODE_W         = $clog2(NUM_DEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_set_vld,
    input  logic [CODE_W-1:0] busy_set_code,
    input  logic              busy_clr_vld,
    input  logic [CODE_W-1:0] busy_clr_code,
    input  logic              done_set_vld,
    input  logic [CODE_W-1:0] done_set_code,
    input  logic              done_clr_vld,
    input  logic [CODE_W-1:0] done_clr_code,
    input  logic              pwr_fail_set,
    input  logic              stk_ovf_set,
    input  logic              fetch,
    input  logic              cmd_ion,
    input  logic              cmd_iof,
    input  logic              cmd_mask_vld,
    input  logic [MASK_W-1:0] cmd_mask_data,
    input  logic              cmd_ack,
    input  logic              cmd_iorst,
    input  logic              skip_req,
    input  logic [1:0]        skip_kind,
    input  logic [CODE_W-1:0] skip_code,
    output logic              irq_take,
    output logic [1:0]        irq_vec,
    output logic              ack_vld,
    output logic [CODE_W-1:0] ack_code,
    output logic              skip_vld,
    output logic              skip_hit
);
    import intc_pkg::*;

    localparam logic [CODE_W-1:0] CPU_CODE = CODE_W'(NUM_DEV - 1);

    typedef struct packed {
        logic               ien;
        logic               dly;
        logic               stk;
        logic               pwr;
        logic [MASK_W-1:0]  mask;
        logic [NUM_DEV-1:0] dis;
        logic               ack_vld;
        logic [CODE_W-1:0]  ack_code;
        logic               skip_vld;
        logic               skip_hit;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NUM_DEV-1:0] busy_f, done_f, dis_new, req;
    logic               req_any;
    logic [CODE_W-1:0]  req_low;
    logic               take;
    logic               t_busy, t_done;

    intc_flag_bank #(.NUM_DEV(NUM_DEV), .CODE_W(CODE_W)) u_busy (
        .clk(clk), .rst_n(rst_n),
        .set_vld(busy_set_vld), .set_code(busy_set_code),
        .clr_vld(busy_clr_vld), .clr_code(busy_clr_code),
        .flags(busy_f)
    );

    intc_flag_bank #(.NUM_DEV(NUM_DEV), .CODE_W(CODE_W)) u_done (
        .clk(clk), .rst_n(rst_n),
        .set_vld(done_set_vld), .set_code(done_set_code),
        .clr_vld(done_clr_vld), .clr_code(done_clr_code),
        .flags(done_f)
    );

    intc_mask_map #(
        .NUM_DEV(NUM_DEV), .MASK_W(MASK_W), .GRP_W(GRP_W),
        .DEVS_PER_GRP(DEVS_PER_GRP), .GRP_FROM_ARRAY(GRP_FROM_ARRAY),
        .DEV_GRP(DEV_GRP)
    ) u_map (
        .mask(cmd_mask_data),
        .dis(dis_new)
    );

    intc_lowest #(.N(NUM_DEV), .W(CODE_W)) u_low (
        .vec(req), .any(req_any), .idx(req_low)
    );

    always_comb begin
        st_d = st_q;

        req  = done_f & ~st_q.dis;
        take = st_q.ien && !st_q.dly && (req_any || st_q.stk);

        if (fetch) st_d.dly = 1'b0;
        if (take) begin
            st_d.ien = 1'b0;
            if (st_q.stk) st_d.stk = 1'b0;
        end
        if (stk_ovf_set)  st_d.stk = 1'b1;
        if (pwr_fail_set) st_d.pwr = 1'b1;
        if (cmd_ion) begin
            st_d.ien = 1'b1;
            st_d.dly = 1'b1;
        end
        if (cmd_iof) st_d.ien = 1'b0;
        if (cmd_mask_vld) begin
            st_d.mask = cmd_mask_data;
            st_d.dis  = dis_new;
        end
        if (cmd_iorst) begin
            st_d.ien  = 1'b0;
            st_d.dly  = 1'b0;
            st_d.stk  = 1'b0;
            st_d.pwr  = 1'b0;
            st_d.mask = '0;
            st_d.dis  = '0;
        end

        st_d.ack_vld = cmd_ack;
        if (cmd_ack) st_d.ack_code = req_any ? req_low : '0;

        t_busy = (skip_code == CPU_CODE) ? st_q.ien : busy_f[skip_code];
        t_done = (skip_code == CPU_CODE) ? st_q.pwr : done_f[skip_code];
        st_d.skip_vld = skip_req;
        if (skip_req) begin
            unique case (skip_kind_e'(skip_kind))
                SK_BUSY: st_d.skip_hit = t_busy;
                SK_IDLE: st_d.skip_hit = !t_busy;
                SK_DONE: st_d.skip_hit = t_done;
                SK_PEND: st_d.skip_hit = !t_done;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_take = take;
    assign irq_vec  = st_q.stk ? VEC_STK_LOC : VEC_DEV_LOC;
    assign ack_vld  = st_q.ack_vld;
    assign ack_code = st_q.ack_code;
    assign skip_vld = st_q.skip_vld;
    assign skip_hit = st_q.skip_hit;

    // R5: no interrupt in the cycle right after enabling
    a_r5_ion_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ion && !cmd_iof && !cmd_iorst) |=> !irq_take);

    // R6: a take drops the enable, so it never lasts two cycles
    a_r6_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_take);

    // R7: a take with stack overflow pending consumes the overflow
    a_r7_stk_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && st_q.stk && !stk_ovf_set) |=> !st_q.stk);

    // R8: disable command blocks the next cycle's take
    a_r8_iof_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_iof |=> !irq_take);

    // R3: mask load captures the command data
    a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mask_vld && !cmd_iorst) |=> (st_q.mask == $past(cmd_mask_data)));

    // R9: acknowledge answers one cycle later
    a_r9_ack_answer: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |=> ack_vld);

    // R12: I/O reset leaves no take and an empty mask
    a_r12_iorst_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_iorst |=> (!irq_take && st_q.mask == '0 && st_q.dis == '0));

endmodule

// File: tb/tb_dev_irq_ctrl.sv
module tb_dev_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy_set_vld = 0, busy_clr_vld = 0, done_set_vld = 0, done_clr_vld = 0;
    logic [5:0] busy_set_code = 0, busy_clr_code = 0, done_set_code = 0, done_clr_code = 0;
    logic       pwr_fail_set = 0, stk_ovf_set = 0, fetch = 0;
    logic       cmd_ion = 0, cmd_iof = 0, cmd_mask_vld = 0, cmd_ack = 0, cmd_iorst = 0;
    logic [15:0] cmd_mask_data = 0;
    logic       skip_req = 0;
    logic [1:0] skip_kind = 0;
    logic [5:0] skip_code = 0;
    logic       irq_take, ack_vld, skip_vld, skip_hit;
    logic [1:0] irq_vec;
    logic [5:0] ack_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dev_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .busy_set_vld(busy_set_vld), .busy_set_code(busy_set_code),
        .busy_clr_vld(busy_clr_vld), .busy_clr_code(busy_clr_code),
        .done_set_vld(done_set_vld), .done_set_code(done_set_code),
        .done_clr_vld(done_clr_vld), .done_clr_code(done_clr_code),
        .pwr_fail_set(pwr_fail_set), .stk_ovf_set(stk_ovf_set), .fetch(fetch),
        .cmd_ion(cmd_ion), .cmd_iof(cmd_iof), .cmd_mask_vld(cmd_mask_vld),
        .cmd_mask_data(cmd_mask_data), .cmd_ack(cmd_ack), .cmd_iorst(cmd_iorst),
        .skip_req(skip_req), .skip_kind(skip_kind), .skip_code(skip_code),
        .irq_take(irq_take), .irq_vec(irq_vec),
        .ack_vld(ack_vld), .ack_code(ack_code),
        .skip_vld(skip_vld), .skip_hit(skip_hit)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_done(input logic [5:0] c);
        done_set_vld = 1; done_set_code = c; step(); done_set_vld = 0;
    endtask
    task automatic clr_done(input logic [5:0] c);
        done_clr_vld = 1; done_clr_code = c; step(); done_clr_vld = 0;
    endtask
    task automatic set_busy(input logic [5:0] c);
        busy_set_vld = 1; busy_set_code = c; step(); busy_set_vld = 0;
    endtask
    task automatic clr_busy(input logic [5:0] c);
        busy_clr_vld = 1; busy_clr_code = c; step(); busy_clr_vld = 0;
    endtask
    task automatic do_mask(input logic [15:0] m);
        cmd_mask_vld = 1; cmd_mask_data = m; step(); cmd_mask_vld = 0;
    endtask
    task automatic do_ion();   cmd_ion = 1; step(); cmd_ion = 0; endtask
    task automatic do_iof();   cmd_iof = 1; step(); cmd_iof = 0; endtask
    task automatic do_fetch(); fetch = 1; step(); fetch = 0; endtask
    task automatic do_iorst(); cmd_iorst = 1; step(); cmd_iorst = 0; endtask

    task automatic skip_test(input logic [1:0] k, input logic [5:0] c, output logic hit);
        skip_req = 1; skip_kind = k; skip_code = c; step(); skip_req = 0;
        hit = skip_hit;
        chk("R10 skip_vld", {31'd0, skip_vld}, 32'd1);
    endtask

    task automatic ack_test(output logic [5:0] c);
        cmd_ack = 1; step(); cmd_ack = 0;
        c = ack_code;
        chk("R9 ack_vld", {31'd0, ack_vld}, 32'd1);
    endtask

    task automatic t_reset();
        logic h; logic [5:0] c;
        chk("R1 irq_take after reset", {31'd0, irq_take}, 0);
        ack_test(c);            chk("R1 ack code empty", {26'd0, c}, 0);
        skip_test(2, 10, h);    chk("R1 done 10 clear", {31'd0, h}, 0);
        skip_test(0, 63, h);    chk("R1 enable off", {31'd0, h}, 0);
        skip_test(2, 63, h);    chk("R1 power-fail off", {31'd0, h}, 0);
    endtask

    task automatic t_flags();
        logic h;
        set_done(10);
        skip_test(2, 10, h);    chk("R2 done 10 set", {31'd0, h}, 1);
        skip_test(3, 10, h);    chk("R10 not-done 10", {31'd0, h}, 0);
        set_busy(5);
        skip_test(0, 5, h);     chk("R10 busy 5", {31'd0, h}, 1);
        skip_test(1, 5, h);     chk("R10 not-busy 5", {31'd0, h}, 0);
        done_set_vld = 1; done_set_code = 10; done_clr_vld = 1; done_clr_code = 10;
        step(); done_set_vld = 0; done_clr_vld = 0;
        skip_test(2, 10, h);    chk("R2 clear wins", {31'd0, h}, 0);
        clr_busy(5);
        skip_test(1, 5, h);     chk("R2 busy cleared", {31'd0, h}, 1);
    endtask

    task automatic t_ack();
        logic [5:0] c;
        set_done(20); set_done(9);
        ack_test(c);            chk("R9 lowest is 9", {26'd0, c}, 9);
        do_mask(16'h0004);
        ack_test(c);            chk("R3 group 2 masks 9", {26'd0, c}, 20);
        clr_done(20);
        ack_test(c);            chk("R4 none requesting", {26'd0, c}, 0);
        do_mask(16'h0000);
        ack_test(c);            chk("R4 unmask restores 9", {26'd0, c}, 9);
        clr_done(9);
        ack_test(c);            chk("R9 empty again", {26'd0, c}, 0);
    endtask

    task automatic t_ion();
        logic h;
        set_done(30);
        do_ion();
        chk("R5 no take before fetch", {31'd0, irq_take}, 0);
        step();
        chk("R5 still waiting", {31'd0, irq_take}, 0);
        do_fetch();
        chk("R6 take after fetch", {31'd0, irq_take}, 1);
        chk("R7 device vector", {30'd0, irq_vec}, 1);
        step();
        chk("R6 take clears enable", {31'd0, irq_take}, 0);
        skip_test(0, 63, h);    chk("R6 enable off after take", {31'd0, h}, 0);
        cmd_ion = 1; fetch = 1; step(); cmd_ion = 0; fetch = 0;
        chk("R5 same-cycle fetch ignored", {31'd0, irq_take}, 0);
        do_fetch();
        chk("R5 later fetch releases", {31'd0, irq_take}, 1);
        step();
        do_mask(16'h0080);
        do_ion(); do_fetch();
        chk("R3 masked group blocks take", {31'd0, irq_take}, 0);
        do_iof();
        do_mask(16'h0000);
        clr_done(30);
    endtask

    task automatic t_iof();
        logic h;
        do_ion();
        skip_test(0, 63, h);    chk("R11 busy on cpu code is enable", {31'd0, h}, 1);
        do_iof();
        skip_test(1, 63, h);    chk("R8 enable cleared", {31'd0, h}, 1);
        cmd_ion = 1; cmd_iof = 1; step(); cmd_ion = 0; cmd_iof = 0;
        skip_test(0, 63, h);    chk("R8 iof wins over ion", {31'd0, h}, 0);
    endtask

    task automatic t_stk();
        do_ion(); do_fetch();
        chk("R6 no request no take", {31'd0, irq_take}, 0);
        stk_ovf_set = 1; step(); stk_ovf_set = 0;
        chk("R6 overflow takes", {31'd0, irq_take}, 1);
        chk("R7 overflow vector", {30'd0, irq_vec}, 3);
        step();
        do_ion(); do_fetch();
        chk("R7 overflow consumed", {31'd0, irq_take}, 0);
        do_iof();
        set_done(12);
        stk_ovf_set = 1; step(); stk_ovf_set = 0;
        do_ion(); do_fetch();
        chk("R7 overflow first", {30'd0, irq_vec}, 3);
        step();
        do_ion(); do_fetch();
        chk("R7 device still pending", {31'd0, irq_take}, 1);
        chk("R7 device vector after", {30'd0, irq_vec}, 1);
        step();
        clr_done(12);
    endtask

    task automatic t_pwr();
        logic h;
        pwr_fail_set = 1; step(); pwr_fail_set = 0;
        skip_test(2, 63, h);    chk("R11 power-fail done", {31'd0, h}, 1);
        skip_test(3, 63, h);    chk("R11 power-fail not-done", {31'd0, h}, 0);
    endtask

    task automatic t_iorst();
        logic h; logic [5:0] c;
        set_done(40);
        do_mask(16'hFFFF);
        stk_ovf_set = 1; step(); stk_ovf_set = 0;
        do_iorst();
        skip_test(0, 63, h);    chk("R12 enable cleared", {31'd0, h}, 0);
        skip_test(2, 63, h);    chk("R12 power-fail cleared", {31'd0, h}, 0);
        ack_test(c);            chk("R12 mask cleared", {26'd0, c}, 40);
        skip_test(2, 40, h);    chk("R12 done kept", {31'd0, h}, 1);
        clr_done(40);
        do_ion(); do_fetch();
        chk("R12 overflow cleared", {31'd0, irq_take}, 0);
        do_iof();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_flags();
        t_ack();
        t_ion();
        t_iof();
        t_stk();
        t_pwr();
        t_iorst();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule